// File: doc/BRIEF.md
# Parallel ADC Handshake Controller

This block runs an 8-bit successive-approximation converter that has a parallel output bus and four control lines: chip select, write strobe, read strobe, and an end-of-conversion flag. All four lines are active low. User logic asks for one conversion with a single-cycle start request. It can also hold a free-running enable, and the block then converts back to back for as long as the enable stays high. The controller pulses the write strobe to launch a conversion. It waits for the end-of-conversion flag, lets the converter settle, and then reads the bus with the read strobe. Each byte it reads appears on the result port with a one-cycle valid pulse.

Every timing window is counted in system-clock cycles. The windows are derived at elaboration time from two parameters, the system clock frequency and the converter clock frequency. They cover the minimum write-pulse width, the settle delay before a read, bus access time, bus release time, and flag-clear time. Only a synchronised copy of the end-of-conversion line is used. If a conversion does not finish within a parameterised number of converter clocks, the controller sets a sticky error flag, releases every strobe and goes back to idle.

Top module: `adc_hs_ctrl`

## Requirements
- R1: After reset, the chip-select, write and read strobes are all high (inactive), and result valid, busy and error are all low.
- R2: A start request in idle drives chip select low and drives the write strobe low for exactly WR_CYC cycles. WR_CYC is the 100 ns minimum rounded up to whole system clocks, at least 1. The write strobe then rises while chip select is still low.
- R3: The read strobe falls no sooner than RD_DELAY_CONV (default 8) converter-clock periods after the end-of-conversion line falls, where the converter-clock period is counted in system clocks rounded up. The controller acts only on the falling edge of a two-flop synchronised copy of that line.
- R4: The read strobe stays low for exactly RDL_CYC cycles, which is the 200 ns access time in whole clocks plus one. The bus is sampled on the last cycle before the read strobe rises. The sampled byte appears on the result port on the following cycle, with a valid pulse exactly one cycle long. The read strobe is only ever low while chip select is low.
- R5: After the read strobe rises, the next write strobe falls no sooner than GAP_CYC cycles later. GAP_CYC covers the longer of the 200 ns bus release and the 450 ns flag clear, plus the synchroniser depth plus one.
- R6: A start request that arrives while busy is ignored: it launches no extra write strobe and produces no extra result.
- R7: If the synchronised end-of-conversion edge has not arrived within TMO_CONV (default 100) converter-clock periods of the write strobe rising, the error output goes high and stays high until reset. All strobes return high and busy falls. Later conversions still work.
- R8: While the free-running enable is high, chip select stays low between conversions. Each read is followed, after the GAP_CYC window, by a new write strobe with no idle cycle in between.
- R9: The result equals the byte the converter drove on the bus, including the extreme codes 0x00 and 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-conversion request, taken only in idle |
| free_run_i | input | 1 | Back-to-back conversion enable |
| adc_intr_n_i | input | 1 | End-of-conversion flag from the converter, active low, asynchronous |
| adc_db_i | input | DW | Converter data bus |
| adc_cs_n_o | output | 1 | Chip select, active low |
| adc_wr_n_o | output | 1 | Write strobe; a conversion starts on its rising edge |
| adc_rd_n_o | output | 1 | Read strobe, active low |
| res_o | output | DW | Last result read |
| res_valid_o | output | 1 | One-cycle pulse marking a new result |
| busy_o | output | 1 | High whenever the controller is not idle |
| err_o | output | 1 | Sticky end-of-conversion timeout flag |

## Verification
The timeout path is the hardest state to reach from the ports, because a working converter always answers well inside the window. The converter model in the bench can be muted so that it accepts the write strobe but never drops its flag. That drives the controller through the full timeout window. The bench then checks the strobes and the sticky error, and shows that a following conversion still completes. Free-running continuity is the other awkward case. It is checked by counting, over the whole run with the enable held, every cycle in which chip select is high while the block is busy.

// File: rtl/adc_hs_pkg.sv
package adc_hs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_LO,
    ST_WAIT_EOC,
    ST_RD_WAIT,
    ST_RD_LO,
    ST_GAP
  } hs_state_t;

  // Whole system clocks covering a span in nanoseconds, never below one.
  function automatic int unsigned cyc_from_ns(longint unsigned ns, longint unsigned sys_hz);
    longint unsigned c;
    c = (ns * sys_hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 64'd0) c = 64'd1;
    return 32'(c);
  endfunction

  // System clocks per converter clock period, rounded up.
  function automatic int unsigned conv_period(longint unsigned sys_hz, longint unsigned conv_hz);
    return 32'((sys_hz + conv_hz - 64'd1) / conv_hz);
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_hs_sync.sv
module adc_hs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      last  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], d_i};
      last  <= chain[STAGES-1];
    end
  end

  assign q_o    = chain[STAGES-1];
  assign fall_o = last & ~chain[STAGES-1];
endmodule

// File: rtl/adc_hs_timer.sv
module adc_hs_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load_i)       cnt <= load_val_i;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/adc_hs_capture.sv
module adc_hs_capture #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] res_o,
  output logic          vld_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= cap_i;
      if (cap_i) res_o <= bus_i;
    end
  end
endmodule

// File: rtl/adc_hs_ctrl.sv
module adc_hs_ctrl
  import adc_hs_pkg::*;
#(
  parameter longint unsigned SYS_HZ        = 50_000_000,
  parameter longint unsigned CONV_HZ       = 640_000,
  parameter int unsigned     DW            = 8,
  parameter int unsigned     SYNC_STAGES   = 2,
  parameter int unsigned     RD_DELAY_CONV = 8,
  parameter int unsigned     TMO_CONV      = 100,
  parameter int unsigned     WR_MIN_NS     = 100,
  parameter int unsigned     ACC_NS        = 200,
  parameter int unsigned     FLOAT_NS      = 200,
  parameter int unsigned     CLR_NS        = 450
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          free_run_i,
  input  logic          adc_intr_n_i,
  input  logic [DW-1:0] adc_db_i,
  output logic          adc_cs_n_o,
  output logic          adc_wr_n_o,
  output logic          adc_rd_n_o,
  output logic [DW-1:0] res_o,
  output logic          res_valid_o,
  output logic          busy_o,
  output logic          err_o
);
  // Derived windows, all in system clocks
  localparam int unsigned CONV_SYS = conv_period(SYS_HZ, CONV_HZ);
  localparam int unsigned WR_CYC   = cyc_from_ns(WR_MIN_NS, SYS_HZ);
  localparam int unsigned RDW_CYC  = RD_DELAY_CONV * CONV_SYS;
  localparam int unsigned RDL_CYC  = cyc_from_ns(ACC_NS, SYS_HZ) + 1;
  localparam int unsigned GAP_CYC  = max_u(cyc_from_ns(FLOAT_NS, SYS_HZ),
                                           cyc_from_ns(CLR_NS, SYS_HZ)) + SYNC_STAGES + 1;
  localparam int unsigned TMO_CYC  = TMO_CONV * CONV_SYS;
  localparam int unsigned MAX_CYC  = max_u(max_u(WR_CYC, RDW_CYC),
                                           max_u(max_u(RDL_CYC, GAP_CYC), TMO_CYC));
  localparam int unsigned TW       = $clog2(MAX_CYC + 1);

  localparam logic [TW-1:0] WR_LD  = TW'(WR_CYC - 1);
  localparam logic [TW-1:0] RDW_LD = TW'(RDW_CYC - 1);
  localparam logic [TW-1:0] RDL_LD = TW'(RDL_CYC - 1);
  localparam logic [TW-1:0] GAP_LD = TW'(GAP_CYC - 1);
  localparam logic [TW-1:0] TMO_LD = TW'(TMO_CYC - 1);

  hs_state_t     st, st_nxt;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;
  logic          intr_sync;
  logic          intr_fall;   // synchronised end-of-conversion edge
  logic          cap_en;      // last read-strobe cycle: sample bus
  logic          tmo_hit;     // timeout expired while waiting
  logic          launch;      // leaving idle
  logic          err_q;

  adc_hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (adc_intr_n_i),
    .q_o    (intr_sync),
    .fall_o (intr_fall)
  );

  adc_hs_timer #(.TW(TW)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  adc_hs_capture #(.DW(DW)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .cap_i (cap_en),
    .bus_i (adc_db_i),
    .res_o (res_o),
    .vld_o (res_valid_o)
  );

  always_comb begin
    st_nxt   = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap_en   = 1'b0;
    tmo_hit  = 1'b0;
    launch   = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (start_i || free_run_i) begin
          st_nxt   = ST_WR_LO;
          tmr_load = 1'b1;
          tmr_val  = WR_LD;
          launch   = 1'b1;
        end
      end
      ST_WR_LO: begin
        if (tmr_zero) begin
          st_nxt   = ST_WAIT_EOC;
          tmr_load = 1'b1;
          tmr_val  = TMO_LD;
        end
      end
      ST_WAIT_EOC: begin
        if (intr_fall) begin
          st_nxt   = ST_RD_WAIT;
          tmr_load = 1'b1;
          tmr_val  = RDW_LD;
        end else if (tmr_zero) begin
          st_nxt  = ST_IDLE;
          tmo_hit = 1'b1;
        end
      end
      ST_RD_WAIT: begin
        if (tmr_zero) begin
          st_nxt   = ST_RD_LO;
          tmr_load = 1'b1;
          tmr_val  = RDL_LD;
        end
      end
      ST_RD_LO: begin
        if (tmr_zero) begin
          st_nxt   = ST_GAP;
          cap_en   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = GAP_LD;
        end
      end
      ST_GAP: begin
        if (tmr_zero) begin
          if (free_run_i) begin
            st_nxt   = ST_WR_LO;
            tmr_load = 1'b1;
            tmr_val  = WR_LD;
          end else begin
            st_nxt = ST_IDLE;
          end
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st <= st_nxt;
      if (tmo_hit) err_q <= 1'b1;
    end
  end

  // Strobes decode straight from the state register
  always_comb begin
    adc_wr_n_o = (st != ST_WR_LO);
    adc_rd_n_o = (st != ST_RD_LO);
    unique case (st)
      ST_IDLE: adc_cs_n_o = 1'b1;
      ST_GAP:  adc_cs_n_o = ~free_run_i;
      default: adc_cs_n_o = 1'b0;
    endcase
  end

  assign busy_o = (st != ST_IDLE);
  assign err_o  = err_q;

endmodule

// File: rtl/adc_hs_chk.sv
module adc_hs_chk #(
  parameter int unsigned RDW_CYC = 8,
  parameter int unsigned GAP_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic wr_n,
  input logic rd_n,
  input logic res_valid,
  input logic err,
  input logic busy,
  input logic intr_fall,
  input logic cap_en,
  input logic tmo_hit,
  input logic launch
);
  int unsigned since_fall;
  int unsigned since_rd;
  logic        rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_fall <= 0;
      since_rd   <= GAP_CYC;
      rd_q       <= 1'b1;
    end else begin
      rd_q <= rd_n;
      if (intr_fall)               since_fall <= 0;
      else if (since_fall < RDW_CYC) since_fall <= since_fall + 1;
      if (rd_n && !rd_q)           since_rd <= 0;
      else if (since_rd < GAP_CYC) since_rd <= since_rd + 1;
    end
  end

  // R2
  wr_rise_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> !cs_n);

  // R3
  rd_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> since_fall >= RDW_CYC);

  // R4
  rd_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !cs_n);

  // R4
  cap_then_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (rd_n && res_valid));

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R5
  bus_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> since_rd >= GAP_CYC - 1);

  // R6
  launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R7
  tmo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (err && !busy && cs_n && wr_n && rd_n));

endmodule

bind adc_hs_ctrl adc_hs_chk #(
  .RDW_CYC (RDW_CYC),
  .GAP_CYC (GAP_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (adc_cs_n_o),
  .wr_n      (adc_wr_n_o),
  .rd_n      (adc_rd_n_o),
  .res_valid (res_valid_o),
  .err       (err_o),
  .busy      (busy_o),
  .intr_fall (intr_fall),
  .cap_en    (cap_en),
  .tmo_hit   (tmo_hit),
  .launch    (launch)
);

// File: tb/sim_adc_hs_ctrl.sv
`timescale 1ns/1ps
module sim_adc_hs_ctrl;
  localparam int CLK_PERIOD = 100;               // 10 MHz system clock
  localparam longint unsigned SYS_F  = 10_000_000;
  localparam longint unsigned CONV_F = 1_000_000;
  localparam int CONV_T = 1000 / CLK_PERIOD;     // system clocks per converter clock
  localparam int E_WR   = 1;                     // 100 ns in 100 ns clocks
  localparam int E_RDW  = 8 * CONV_T;
  localparam int E_RDL  = 200 / CLK_PERIOD + 1;
  localparam int E_GAP  = (450 + CLK_PERIOD - 1) / CLK_PERIOD + 2 + 1;
  localparam int E_TMO  = 100 * CONV_T;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, free_run = 1'b0, intr_n = 1'b1;
  logic [7:0] db, res;
  logic cs_n, wr_n, rd_n, res_valid, busy, err;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] vin_p = 8'h00, vin_n = 8'h00;
  bit mute = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_hs_ctrl #(.SYS_HZ(SYS_F), .CONV_HZ(CONV_F)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .free_run_i(free_run),
    .adc_intr_n_i(intr_n), .adc_db_i(db), .adc_cs_n_o(cs_n), .adc_wr_n_o(wr_n),
    .adc_rd_n_o(rd_n), .res_o(res), .res_valid_o(res_valid), .busy_o(busy), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver side of the scoreboard: expected code for the analog pair
  task automatic drive_expect(input logic [7:0] p, input logic [7:0] n, output logic [7:0] code);
    code = (n >= p) ? 8'h00 : 8'(p - n);
    exp_q.push_back(code);
  endtask

  // Behavioural converter
  logic [7:0] stub_code = 8'h00;
  int conv_left = 0, clr_left = 0, rd_lo_cnt = 0, n_conv = 0;
  logic wr_q = 1'b1, rd_q = 1'b1;

  always @(posedge clk) begin : stub
    logic [7:0] c;
    wr_q <= wr_n;
    rd_q <= rd_n;
    rd_lo_cnt <= rd_n ? 0 : rd_lo_cnt + 1;
    if (wr_n && !wr_q && !cs_n && !mute) begin
      drive_expect(vin_p, vin_n, c);
      stub_code <= c;
      conv_left <= 660 + (n_conv * 37) % 151;
      n_conv    <= n_conv + 1;
    end else if (conv_left > 0) begin
      if (conv_left == 1) intr_n <= 1'b0;
      conv_left <= conv_left - 1;
    end
    if ((!wr_n && wr_q) || (!rd_n && rd_q)) clr_left <= 4;
    else if (clr_left > 0) begin
      if (clr_left == 1) intr_n <= 1'b1;
      clr_left <= clr_left - 1;
    end
  end

  assign db = (!rd_n && !cs_n && rd_lo_cnt >= 2) ? stub_code : 8'hFF;

  // Monitor: timing checks and scoreboard compare
  int cyc = 0, wr_lo_len = 0, rd_lo_len = 0, n_res = 0, n_wr_rise = 0, cont_cs_hi = 0;
  int intr_fall_cyc = -1000000, rd_rise_cyc = -1000000;
  logic p_wr = 1'b1, p_rd = 1'b1, p_intr = 1'b1, p_vld = 1'b0;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (!wr_n) wr_lo_len++;
    if (!rd_n) rd_lo_len++;
    if (!intr_n && p_intr) intr_fall_cyc = cyc;
    if (wr_n && !p_wr) begin
      n_wr_rise++;
      chk(wr_lo_len == E_WR, "R2 write low width", wr_lo_len, E_WR);
      chk(!cs_n, "R2 cs low at write rise", cs_n, 0);
      wr_lo_len = 0;
    end
    if (!wr_n && p_wr)
      chk(cyc - rd_rise_cyc >= E_GAP, "R5 read-to-write gap", cyc - rd_rise_cyc, E_GAP);
    if (!rd_n && p_rd)
      chk(cyc - intr_fall_cyc >= E_RDW, "R3 settle before read", cyc - intr_fall_cyc, E_RDW);
    if (rd_n && !p_rd) begin
      chk(rd_lo_len == E_RDL, "R4 read low width", rd_lo_len, E_RDL);
      rd_lo_len = 0;
      rd_rise_cyc = cyc;
    end
    if (res_valid) begin
      chk(!p_vld, "R4 valid single cycle", 1, 0);
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected result", res, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(res == e, "R9 result value", res, e);
      end
      n_res++;
    end
    if (free_run && busy && cs_n) cont_cs_hi++;
    p_wr = wr_n; p_rd = rd_n; p_intr = intr_n; p_vld = res_valid;
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic one_conv(input logic [7:0] p, input logic [7:0] n);
    int target;
    vin_p = p; vin_n = n; target = n_res + 1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (n_res < target) @(negedge clk);
    wait_idle();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int w0, r0, target;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cs_n && wr_n && rd_n, "R1 strobes idle", {cs_n, wr_n, rd_n}, 3'b111);
    chk(!res_valid && !busy && !err, "R1 flags low", {res_valid, busy, err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n && wr_n && rd_n && !busy, "R1 idle after release", {cs_n, wr_n, rd_n, busy}, 4'b1110);

    // R9 several codes including extremes
    one_conv(8'h5A, 8'h00);
    one_conv(8'hC3, 8'h10);
    one_conv(8'h20, 8'h40);
    one_conv(8'h33, 8'h33);
    one_conv(8'hFF, 8'h00);
    chk(n_res == 5, "R9 result count", n_res, 5);

    // R6 start while busy is ignored
    w0 = n_wr_rise; r0 = n_res;
    vin_p = 8'h81; vin_n = 8'h01;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 5; i++) begin
      repeat (100) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (n_res < r0 + 1) @(negedge clk);
    wait_idle();
    repeat (20) @(negedge clk);
    chk(n_wr_rise - w0 == 1, "R6 write strobes for one request", n_wr_rise - w0, 1);
    chk(n_res - r0 == 1, "R6 results for one request", n_res - r0, 1);

    // R5 start held high: back-to-back single conversions respect the gap
    vin_p = 8'h44; vin_n = 8'h04;
    target = n_res + 2;
    @(negedge clk) start = 1'b1;
    while (n_res < target) @(negedge clk);
    start = 1'b0;
    wait_idle();

    // R8 free-running
    r0 = n_res;
    vin_p = 8'h10; vin_n = 8'h00;
    @(negedge clk) free_run = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      while (n_res < r0 + k) @(negedge clk);
      vin_p = 8'(8'h10 + 8'(k * 8'h21));
      if (k == 3) free_run = 1'b0;
    end
    wait_idle();
    chk(cont_cs_hi == 0, "R8 cs stayed low", cont_cs_hi, 0);
    chk(n_res - r0 == 3, "R8 results in free run", n_res - r0, 3);

    // R7 timeout with a silent converter
    chk(!err, "R7 no error before timeout", err, 0);
    mute = 1'b1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (E_TMO + 100) @(negedge clk);
    chk(err, "R7 error raised", err, 1);
    chk(!busy && cs_n && wr_n && rd_n, "R7 strobes released", {busy, cs_n, wr_n, rd_n}, 4'b0111);
    mute = 1'b0;
    one_conv(8'h7E, 8'h01);
    chk(err, "R7 error sticky", err, 1);

    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule